// File: doc/BRIEF.md
# External Bus Address-Strobe Wait-State Stretcher

This block drives the address strobe of an external memory bus and lengthens it by a programmable number of wait cycles. The 22-bit address space is split into two halves by its top bit, and each half has its own 2-bit stretch setting. An access request is accepted only when no strobe is running. On acceptance, the address and the stretch value chosen for its half are captured. The strobe then stays high for one base cycle plus the chosen number of wait cycles. A one-cycle completion pulse follows.

The stretch settings live in a small 8-bit configuration register. It comes out of reset at the slowest setting in both halves, so that an unknown slow device can be reached before software tunes the timing. Two bits of that register have fixed values: one reserved bit always reads 0, and one bit must stay 1 and is forced back to 1 on every write. Two further bits are plain read/write storage.

Top module: `strobe_wait_unit`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x1F, `as_strobe` and `acc_done` are 0, and `acc_ready` is 1.
- R2: A write with `cfg_we` high stores bits 6, 5 and 3:0 of `cfg_wdata`. From the next cycle, bit 7 of `cfg_rdata` reads 0 and bit 4 reads 1, whatever was written to them.
- R3: When bit 21 of `req_addr` is 0, the access uses the lower-half field in register bits 3:2, with value N from 0 to 3. `as_strobe` is then high for exactly 1+N consecutive cycles.
- R4: When bit 21 of `req_addr` is 1, the access uses the upper-half field in register bits 1:0, with value N. `as_strobe` is then high for exactly 1+N consecutive cycles.
- R5: `acc_done` is high for exactly one cycle, the cycle right after the last strobe cycle. `acc_done` is never high while `as_strobe` is high.
- R6: `acc_ready` is 0 in every strobe cycle. A request raised while the strobe is high is dropped and produces no strobe.
- R7: If a request is held high across an access, the next strobe starts after exactly one low cycle, which is the done cycle.
- R8: The stretch value is captured in the cycle the request is accepted. A register write later in the access, or in that same acceptance cycle, leaves the length of that access unchanged and takes effect from the next request.
- R9: `as_addr` shows the address captured at acceptance in every strobe cycle, even if `req_addr` changes during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register read value |
| req | input | 1 | Access request |
| req_addr | input | 22 | Access address; bit 21 selects the half |
| acc_ready | output | 1 | A request is accepted in this cycle if raised |
| as_strobe | output | 1 | Stretched address strobe |
| as_addr | output | 22 | Address captured for the running access |
| acc_done | output | 1 | One-cycle completion pulse |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge, and so can a write and a running strobe. The bench raises `cfg_we` and `req` in the same cycle and checks that the strobe length follows the old field value. It then checks that the following access uses the new value. It also rewrites the register halfway through a long strobe and checks that the length the scoreboard queued at acceptance is still met.

// File: rtl/strw_pkg.sv
package strw_pkg;

    localparam int ADDR_W   = 22;
    localparam int FIELD_W  = 2;
    localparam int CFG_W    = 8;

    // Bit positions inside the configuration register.
    localparam int HI_LSB   = 0;   // upper-half stretch field, bits 1:0
    localparam int LO_LSB   = 2;   // lower-half stretch field, bits 3:2
    localparam int KEEP_BIT = 4;   // must read 1
    localparam int RSV_BIT  = 7;   // reads 0

    localparam logic [CFG_W-1:0] CFG_RESET = 8'h1F;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] lo_wait;
        logic [FIELD_W-1:0] hi_wait;
    } wait_cfg_t;

    // Forces the fixed bits of a value written to the register.
    function automatic logic [CFG_W-1:0] cfg_sanitize(input logic [CFG_W-1:0] d);
        logic [CFG_W-1:0] r;
        r           = d;
        r[RSV_BIT]  = 1'b0;
        r[KEEP_BIT] = 1'b1;
        return r;
    endfunction

    function automatic wait_cfg_t cfg_unpack(input logic [CFG_W-1:0] q);
        wait_cfg_t c;
        c.lo_wait = q[LO_LSB +: FIELD_W];
        c.hi_wait = q[HI_LSB +: FIELD_W];
        return c;
    endfunction

endpackage

// File: rtl/strw_cfg_reg.sv
module strw_cfg_reg
    import strw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output wait_cfg_t        waits
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= cfg_sanitize(wdata);
        end
    end

    assign rdata = cfg_q;
    assign waits = cfg_unpack(cfg_q);

    // R2: written storage bits appear on the read port one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[3:0] == $past(wdata[3:0]) && rdata[6:5] == $past(wdata[6:5])));

endmodule

// File: rtl/strw_field_sel.sv
module strw_field_sel
    import strw_pkg::*;
(
    input  wait_cfg_t          waits,
    input  logic               upper_half,
    output logic [FIELD_W-1:0] n_wait
);

    always_comb begin
        if (upper_half) n_wait = waits.hi_wait;
        else            n_wait = waits.lo_wait;
    end

endmodule

// File: rtl/strw_seq.sv
module strw_seq
    import strw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] n_wait,
    output logic          ready,
    output logic          strobe,
    output logic [AW-1:0] addr_q,
    output logic          done
);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = req && (state_q != ST_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_STROBE: begin
                    if (cnt_q == '0) state_q <= ST_DONE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: begin
                    if (accept) begin
                        state_q <= ST_STROBE;
                        cnt_q   <= n_wait;
                        addr_q  <= req_addr;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign strobe = (state_q == ST_STROBE);
    assign done   = (state_q == ST_DONE);
    assign ready  = (state_q != ST_STROBE);

    // R5: the done pulse sits right after the strobe falls
    a_r5_done_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> done);

    // R5: done and strobe are never high together
    a_r5_done_excl: assert property (@(posedge clk) disable iff (rst)
        done |-> !strobe);

    // R6: a strobe with wait cycles left keeps running
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (strobe && cnt_q != '0) |=> strobe);

    // R8: the captured count only steps down during a strobe
    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> (cnt_q == $past(cnt_q) - 1'b1));

    // R9: captured address stays put for the whole strobe
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(addr_q));

endmodule

// File: rtl/strobe_wait_unit.sv
module strobe_wait_unit
    import strw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              acc_ready,
    output logic              as_strobe,
    output logic [ADDR_W-1:0] as_addr,
    output logic              acc_done
);

    wait_cfg_t          waits;
    logic [FIELD_W-1:0] n_wait;

    strw_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .waits (waits)
    );

    strw_field_sel u_sel (
        .waits      (waits),
        .upper_half (req_addr[ADDR_W-1]),
        .n_wait     (n_wait)
    );

    strw_seq #(
        .AW (ADDR_W),
        .CW (FIELD_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_addr (req_addr),
        .n_wait   (n_wait),
        .ready    (acc_ready),
        .strobe   (as_strobe),
        .addr_q   (as_addr),
        .done     (acc_done)
    );

endmodule

// File: tb/strobe_wait_unit_bench.sv
`timescale 1ns/1ps
module strobe_wait_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req = 1'b0;
    logic [21:0] req_addr = '0;
    logic        acc_ready, as_strobe, acc_done;
    logic [21:0] as_addr;

    int errors = 0;
    int checks = 0;

    typedef struct {
        int          len;
        logic [21:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    strobe_wait_unit u_strobe_wait_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req(req), .req_addr(req_addr),
        .acc_ready(acc_ready), .as_strobe(as_strobe), .as_addr(as_addr),
        .acc_done(acc_done)
    );

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req_tag, what, act, exp);
        end
    endtask

    // ---------------- monitor / scoreboard ----------------
    logic  prev_s = 1'b0;
    int    run_len = 0;
    int    gap_len = 1000;
    int    last_gap = 1000;
    bit    stray = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (as_strobe) begin
                check(acc_ready == 1'b0, "R6", "ready during strobe", acc_ready, 0);
                check(acc_done == 1'b0, "R5", "done during strobe", acc_done, 0);
                if (!prev_s) begin
                    run_len  = 1;
                    last_gap = gap_len;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "strobe with no accepted request", 1, 0);
                        stray = 1'b1;
                    end
                end else begin
                    run_len++;
                end
                if (exp_q.size() != 0)
                    check(as_addr == exp_q[0].addr, "R9", "captured address",
                          as_addr, exp_q[0].addr);
            end else begin
                if (prev_s) begin
                    gap_len = 1;
                    check(acc_done == 1'b1, "R5", "done after strobe", acc_done, 1);
                    if (!stray && exp_q.size() != 0) begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(run_len == e.len, e.tag, "strobe length", run_len, e.len);
                    end
                    stray = 1'b0;
                end else begin
                    gap_len++;
                    check(acc_done == 1'b0, "R5", "done without strobe end", acc_done, 0);
                end
            end
            prev_s = as_strobe;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic cfg_write(input logic [7:0] d, input logic [7:0] exp_rd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == exp_rd, "R2", "register readback", cfg_rdata, exp_rd);
    endtask

    task automatic access(input logic [21:0] a, input int n, input string tag);
        exp_t e;
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        req = 1'b1; req_addr = a;
        e.len = 1 + n; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0 || as_strobe) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [21:0] LO_A = 22'h012345;
    localparam logic [21:0] HI_A = 22'h2ABCDE;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 8'h1F, "R1", "reset register", cfg_rdata, 8'h1F);
        check(as_strobe == 1'b0, "R1", "reset strobe", as_strobe, 0);
        check(acc_done == 1'b0, "R1", "reset done", acc_done, 0);
        check(acc_ready == 1'b1, "R1", "reset ready", acc_ready, 1);

        // default slowest stretch in both halves
        access(LO_A, 3, "R3"); wait_quiet();
        access(HI_A, 3, "R4"); wait_quiet();

        // R2: fixed bits forced, lower=1 upper=2
        cfg_write(8'hC6, 8'h56);
        access(LO_A, 1, "R3"); wait_quiet();
        access(HI_A, 2, "R4"); wait_quiet();

        // zero wait boundary
        cfg_write(8'h00, 8'h10);
        access(LO_A, 0, "R3"); wait_quiet();
        access(HI_A, 0, "R4"); wait_quiet();
        cfg_write(8'h30, 8'h30);
        cfg_write(8'h09, 8'h19);
        access(HI_A, 1, "R4"); wait_quiet();

        // R6: request during strobe is dropped
        cfg_write(8'h0F, 8'h1F);
        access(LO_A, 3, "R6");
        @(negedge clk);
        req = 1'b1; req_addr = HI_A;
        @(negedge clk);
        req = 1'b0; req_addr = 22'h3FFFFF;   // R9: address changes mid-access
        wait_quiet();
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && !as_strobe, "R6", "no extra strobe", as_strobe, 0);

        // R7: held request, back-to-back with one low cycle
        cfg_write(8'h04, 8'h14);
        begin
            exp_t e;
            @(negedge clk);
            req = 1'b1; req_addr = LO_A;
            e.len = 2; e.addr = LO_A; e.tag = "R7";
            exp_q.push_back(e);
            exp_q.push_back(e);
            repeat (4) @(posedge clk);
            @(negedge clk);
            req = 1'b0;
        end
        wait_quiet();
        check(last_gap == 1, "R7", "gap between strobes", last_gap, 1);

        // R8: write in the middle of an access
        cfg_write(8'h0C, 8'h1C);
        access(LO_A, 3, "R8");
        cfg_write(8'h00, 8'h10);
        wait_quiet();
        access(LO_A, 0, "R8"); wait_quiet();

        // R8: write on the same edge as acceptance
        begin
            exp_t e;
            @(negedge clk);
            req = 1'b1; req_addr = LO_A; cfg_we = 1'b1; cfg_wdata = 8'h0C;
            e.len = 1; e.addr = LO_A; e.tag = "R8";
            exp_q.push_back(e);
            @(negedge clk);
            req = 1'b0; cfg_we = 1'b0;
        end
        wait_quiet();
        access(LO_A, 3, "R8"); wait_quiet();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule